// File: doc/BRIEF.md
# Operand Stack with Register-Cached Top

This block is a 16-bit evaluation stack holding up to 1024 values. The topmost value sits in a dedicated register. Everything below it lives in a memory array of 1023 words, addressed by a downward-growing pointer. Because the top comes from a register and the element beneath it comes from a combinational read of the array, both operands of a binary operation are visible in the same cycle. The result of that operation can be written back to the top as the second operand is discarded, so the whole operation takes one clock.

A command is offered on `cmd_valid` with a 2-bit `cmd_op` and a 16-bit `cmd_data`. `cmd_data` carries the value to push, or the result from the external arithmetic unit. Every offered command is taken on the clock edge where it is offered, so there is no back-pressure and no ready signal. An illegal command sets a sticky error flag and leaves the stack as it was.

The pointer moves in a fixed order:
- A push first moves the pointer down one word, then writes the old top into memory at that address.
- A pop first loads the top from memory at the pointer, then moves the pointer up one word.

Top module: `opstack_cached_top`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `err`=0, and both `top_data` and `next_data` read 0. `top_data` reads 0 whenever the stack is empty. `next_data` reads 0 whenever the stack holds fewer than two values. A reset also clears `err`.
- R2: A push (`cmd_op`=0) onto an empty stack makes `top_data` equal the pushed value on the next cycle, clears `empty`, and leaves `next_data` at 0.
- R3: A push (`cmd_op`=0) onto a non-empty, non-full stack makes the pushed value the new top. The previous top becomes `next_data`, and deeper values keep their last-in-first-out order.
- R4: A pop (`cmd_op`=1) on a non-empty stack removes the top. The former next-to-top becomes `top_data` and the value below it becomes `next_data`. Popping the only value sets `empty`.
- R5: A replace (`cmd_op`=2) on a non-empty stack sets `top_data` to `cmd_data`. `next_data` and the depth stay the same.
- R6: A pop-replace (`cmd_op`=3) on a stack holding at least two values completes in one cycle:
  - the depth drops by one;
  - `top_data` becomes `cmd_data`;
  - `next_data` becomes the value that was third from the top.
- R7: `full` is 1 exactly when 1024 values are held, and `empty` is 1 exactly when none are held. The two flags are never both 1.
- R8: A push while `full` sets `err` and leaves the contents, `top_data`, `next_data` and flags unchanged.
- R9: Each of these sets `err` and changes nothing else:
  - a pop or replace on an empty stack;
  - a pop-replace on a stack holding fewer than two values.
- R10: `err` stays at 1 from the cycle after it is set until reset, whatever commands follow.
- R11: While `cmd_valid` is 0, `top_data`, `next_data`, `empty`, `full` and `err` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered and taken this cycle |
| cmd_op | input | 2 | 0 push, 1 pop, 2 replace, 3 pop-replace |
| cmd_data | input | 16 | Value to push, or result for replace/pop-replace |
| top_data | output | 16 | Current top value (0 when empty) |
| next_data | output | 16 | Value below the top (0 when fewer than two held) |
| empty | output | 1 | No values held |
| full | output | 1 | 1024 values held |
| err | output | 1 | Sticky overflow/underflow indicator |

## Verification
The hardest state to reach is the full boundary. There, the pointer sits at the lowest memory address behind a valid top, and a push must be refused while the pop next to it must still work. The stimulus reaches this state with an unbroken run of 1024 pushes of distinct values. At the boundary it tries one more push, then alternates pops and pushes across the edge. The other edge is the one-value and two-value region, where the memory is empty. The stimulus covers it by draining the stack and then trying each operation that needs more values than the stack holds.

// File: rtl/opstack_pkg.sv
package opstack_pkg;

  typedef enum logic [1:0] {
    OP_PUSH   = 2'd0,
    OP_POP    = 2'd1,
    OP_REPL   = 2'd2,
    OP_POPREP = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    TOP_HOLD = 2'd0,
    TOP_CMD  = 2'd1,
    TOP_MEM  = 2'd2
  } top_src_e;

endpackage

// File: rtl/opstack_ctrl.sv
module opstack_ctrl
  import opstack_pkg::*;
#(
  parameter int MEM_DEPTH = 1023,
  parameter int PTR_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  output logic [PTR_W-1:0] rd_addr,
  output logic [PTR_W-1:0] wr_addr,
  output logic             mem_we,
  output top_src_e         top_src,
  output logic             top_vld,
  output logic             has_next,
  output logic             is_full,
  output logic             err_flag
);

  localparam logic [PTR_W-1:0] PTR_BASE = PTR_W'(MEM_DEPTH);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             vld_q, vld_d;
  logic             err_q;
  logic             legal;
  logic             mem_empty;

  assign mem_empty = (ptr_q == PTR_BASE);
  assign is_full   = vld_q && (ptr_q == '0);
  assign has_next  = vld_q && !mem_empty;

  always_comb begin
    legal   = 1'b0;
    ptr_d   = ptr_q;
    vld_d   = vld_q;
    mem_we  = 1'b0;
    top_src = TOP_HOLD;
    if (cmd_valid) begin
      unique case (stk_op_e'(cmd_op))
        OP_PUSH: begin
          legal = !is_full;
          if (legal) begin
            top_src = TOP_CMD;
            vld_d   = 1'b1;
            if (vld_q) begin
              mem_we = 1'b1;
              ptr_d  = ptr_q - PTR_ONE;
            end
          end
        end
        OP_POP: begin
          legal = vld_q;
          if (legal) begin
            if (has_next) begin
              top_src = TOP_MEM;
              ptr_d   = ptr_q + PTR_ONE;
            end else begin
              vld_d = 1'b0;
            end
          end
        end
        OP_REPL: begin
          legal = vld_q;
          if (legal) top_src = TOP_CMD;
        end
        OP_POPREP: begin
          legal = has_next;
          if (legal) begin
            top_src = TOP_CMD;
            ptr_d   = ptr_q + PTR_ONE;
          end
        end
        default: legal = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= PTR_BASE;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      vld_q <= vld_d;
      if (cmd_valid && !legal) err_q <= 1'b1;
    end
  end

  assign rd_addr  = ptr_q;
  assign wr_addr  = ptr_q - PTR_ONE;
  assign top_vld  = vld_q;
  assign err_flag = err_q;

endmodule

// File: rtl/opstack_mem.sv
module opstack_mem #(
  parameter int WORDS  = 1023,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = (raddr < ADDR_W'(WORDS)) ? store[raddr] : '0;

endmodule

// File: rtl/opstack_topreg.sv
module opstack_topreg
  import opstack_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  top_src_e          src,
  input  logic [DATA_W-1:0] cmd_val,
  input  logic [DATA_W-1:0] mem_val,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (src)
        TOP_CMD: q <= cmd_val;
        TOP_MEM: q <= mem_val;
        default: q <= q;
      endcase
    end
  end

endmodule

// File: rtl/opstack_cached_top.sv
module opstack_cached_top
  import opstack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] top_data,
  output logic [DATA_W-1:0] next_data,
  output logic              empty,
  output logic              full,
  output logic              err
);

  localparam int MEM_DEPTH = DEPTH - 1;
  localparam int PTR_W     = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH + 1) : 1;

  logic [PTR_W-1:0]  rd_addr, wr_addr;
  logic              mem_we;
  top_src_e          top_src;
  logic              top_vld, has_next;
  logic [DATA_W-1:0] top_q, mem_rd;

  opstack_ctrl #(.MEM_DEPTH(MEM_DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .rd_addr  (rd_addr),
    .wr_addr  (wr_addr),
    .mem_we   (mem_we),
    .top_src  (top_src),
    .top_vld  (top_vld),
    .has_next (has_next),
    .is_full  (full),
    .err_flag (err)
  );

  opstack_mem #(.WORDS(MEM_DEPTH), .DATA_W(DATA_W), .ADDR_W(PTR_W)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(wr_addr),
    .wdata(top_q),
    .raddr(rd_addr),
    .rdata(mem_rd)
  );

  opstack_topreg #(.DATA_W(DATA_W)) u_top (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (top_src),
    .cmd_val(cmd_data),
    .mem_val(mem_rd),
    .q      (top_q)
  );

  assign empty     = !top_vld;
  assign top_data  = top_vld  ? top_q  : '0;
  assign next_data = has_next ? mem_rd : '0;

endmodule

// File: rtl/opstack_chk.sv
module opstack_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [DATA_W-1:0] cmd_data,
  input logic [DATA_W-1:0] top_data,
  input logic [DATA_W-1:0] next_data,
  input logic              empty,
  input logic              full,
  input logic              err
);

  assert_empty_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (top_data == '0 && next_data == '0));

  assert_push_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && !full) |=> (top_data == $past(cmd_data) && !empty));

  assert_push_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && !full && !empty) |=> (next_data == $past(top_data)));

  assert_popreplace_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3 && !empty && next_data != '0) |=> (top_data == $past(cmd_data)));

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && full) |=> (full && err && $stable(top_data) && $stable(next_data)));

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && empty) |=> (empty && err));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(top_data) && $stable(next_data) && $stable(empty)
                    && $stable(full) && $stable(err)));

endmodule

bind opstack_cached_top opstack_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_op   (cmd_op),
  .cmd_data (cmd_data),
  .top_data (top_data),
  .next_data(next_data),
  .empty    (empty),
  .full     (full),
  .err      (err)
);

// File: tb/tb_opstack_cached_top.sv
module tb_opstack_cached_top;

  localparam int CAP = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_data = 16'd0;
  logic [15:0] top_data, next_data;
  logic        empty, full, err;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int model[$];
  bit m_err = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  opstack_cached_top dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .top_data(top_data), .next_data(next_data),
    .empty(empty), .full(full), .err(err)
  );

  task automatic chk1(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int et, en;
    et = (model.size() > 0) ? model[0] : 0;
    en = (model.size() > 1) ? model[1] : 0;
    chk1(tag, "top_data", int'(top_data), et);
    chk1(tag, "next_data", int'(next_data), en);
    chk1(tag, "empty", int'(empty), int'(model.size() == 0));
    chk1(tag, "full", int'(full), int'(model.size() == CAP));
    chk1(tag, "err", int'(err), int'(m_err));
  endtask

  task automatic model_step(bit v, logic [1:0] op, logic [15:0] d);
    if (!v) return;
    case (op)
      2'd0: if (model.size() == CAP) m_err = 1; else model.push_front(int'(d));
      2'd1: if (model.size() == 0) m_err = 1; else void'(model.pop_front());
      2'd2: if (model.size() == 0) m_err = 1; else model[0] = int'(d);
      default: if (model.size() < 2) m_err = 1;
               else begin void'(model.pop_front()); model[0] = int'(d); end
    endcase
  endtask

  task automatic step(string tag, bit v, logic [1:0] op, logic [15:0] d);
    cmd_valid = v; cmd_op = op; cmd_data = d;
    @(posedge clk);
    model_step(v, op, d);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0;
    repeat (3) @(posedge clk);
    model.delete(); m_err = 0;
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
  endtask

  function automatic logic [15:0] rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  initial begin
    @(negedge clk);
    do_reset();
    // R2 / R3 pushes
    step("R2", 1, 2'd0, 16'h1111);
    step("R3", 1, 2'd0, 16'h2222);
    step("R3", 1, 2'd0, 16'h3333);
    step("R3", 1, 2'd0, 16'h4444);
    step("R5", 1, 2'd2, 16'h5555);
    step("R11", 0, 2'd1, 16'h0000);
    step("R11", 0, 2'd0, 16'h9999);
    step("R6", 1, 2'd3, 16'h6666);
    step("R6", 1, 2'd3, 16'h7777);
    step("R4", 1, 2'd1, 16'h0);
    step("R9", 1, 2'd3, 16'hBEEF);
    step("R4", 1, 2'd1, 16'h0);
    step("R9", 1, 2'd1, 16'h0);
    step("R9", 1, 2'd2, 16'hDEAD);
    step("R10", 1, 2'd0, 16'h0ABC);
    step("R10", 1, 2'd1, 16'h0);
    step("R10", 0, 2'd0, 16'h0);
    do_reset();
    step("R9", 1, 2'd2, 16'h1234);
    do_reset();
    step("R9", 1, 2'd0, 16'h00AA);
    step("R9", 1, 2'd3, 16'h00BB);
    do_reset();
    // fill to capacity
    for (int i = 0; i < CAP; i++) step("R7", 1, 2'd0, 16'(i * 7 + 3));
    step("R8", 1, 2'd0, 16'hFFFF);
    step("R7", 1, 2'd1, 16'h0);
    step("R7", 1, 2'd0, 16'hC0DE);
    step("R8", 1, 2'd0, 16'hF00D);
    step("R11", 0, 2'd3, 16'h0);
    for (int i = 0; i < 40; i++) step("R6", 1, 2'd3, 16'(i + 16'h100));
    for (int i = 0; i < 20; i++) step("R4", 1, 2'd1, 16'h0);
    do_reset();
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] r;
      logic [1:0] op;
      r = rnd();
      op = (r[3:0] < 4'd7) ? 2'd0 : r[5:4];
      if (model.size() < 2 && op == 2'd3) op = 2'd0;
      if (model.size() == 0 && op != 2'd0) op = 2'd0;
      step("R3", r[15:13] != 3'd0, op, rnd());
    end
    for (int i = 0; i < CAP + 2; i++) step("R4", 1, 2'd1, 16'h0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule